// File: doc/BRIEF.md
# Issue Interlock for a Pipeline with Unequal Unit Latencies

This block sits at the operand-fetch stage of an in-order, single-issue pipeline whose execution side branches into units of different depth: an integer unit of one stage, a memory unit of three stages, a floating-point unit of six stages and a branch unit that produces no register result. Every unit that writes a register shares one write port into the register file. Each cycle the upstream stage offers one candidate instruction: its two source register numbers, its destination register number and its unit class. The block decides in the same cycle whether that candidate may enter its unit (`accept`) or must wait (`stall`). Once accepted, an instruction is never held again.

Two structures hold the state. The first is a per-register countdown of the cycles left until a pending write lands. It answers both the read-after-write question (is a source still pending?) and the write-after-write question (would the new write land before an older one to the same register?). The second is a shift register of booked write-back cycles. It refuses any candidate whose write would fall in a cycle that already belongs to another instruction. Each hazard kind is reported on its own flag, so the upstream stage and performance counters can see why the candidate waits. The upstream stage keeps offering a stalled candidate, or a younger one is held behind it, so issue stays in program order.

Top module: `ilk_issue_gate`

## Requirements
- R1: Reset clears every pending write and every booked write-back slot, so the first instruction offered after reset is accepted whatever registers it names.
- R2: `stall` and `accept` are never high together. With `iss_valid` low both are low and no hazard flag is raised. With `iss_valid` high exactly one of them is high.
- R3: The class code sets the latency: 0 is integer (1 cycle), 1 is memory (3 cycles), 2 is floating point (6 cycles), 3 is branch (no result). A register-writing instruction of latency L accepted in cycle t blocks any candidate that reads its destination through cycle t+L. Such a reader is first accepted in cycle t+L+1.
- R4: The read-after-write check covers both source fields. A match on the second source alone stalls just as a match on the first does.
- R5: A register-writing candidate stalls with `waw_hit` while an older pending write to the same destination would land in the same cycle as its own write-back or later.
- R6: A register-writing candidate of latency L offered in cycle c stalls with `port_hit` when an instruction accepted earlier writes back in cycle c+L, even when the registers are unrelated.
- R7: A branch (class 3) is checked only against its sources. It never raises `waw_hit` or `port_hit`, books no write-back slot, and leaves no pending write on the register named in its destination field.
- R8: A candidate that is not accepted, whether because `iss_valid` is low or because it stalls, changes no state. A later reader of its destination is not delayed by it.
- R9: `raw_hit`, `waw_hit` and `port_hit` are each raised independently when their own condition holds, so more than one can be high in a cycle. `stall` is never high without at least one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | A candidate instruction is offered this cycle |
| iss_cls | input | 2 | Unit class: 0 integer, 1 memory, 2 floating point, 3 branch |
| iss_src1 | input | AW (5) | First source register number |
| iss_src2 | input | AW (5) | Second source register number |
| iss_dst | input | AW (5) | Destination register number (ignored for branches) |
| stall | output | 1 | Candidate must be held this cycle |
| accept | output | 1 | Candidate enters its unit at the coming clock edge |
| raw_hit | output | 1 | A source is still pending from an older instruction |
| waw_hit | output | 1 | Destination write would not land after an older pending write |
| port_hit | output | 1 | Write-back cycle already booked by another instruction |

## Verification
Dependent chains are run back to back on integer, memory and floating-point producers. The count of stall cycles before the reader issues separates a correct latency per class from an off-by-one countdown. A long producer followed by shorter writers to the same register separates the write-ordering check from the write-port check: one candidate trips only the first, one trips both, and one passes both once the slots clear. Independent short writers placed under a long producer's write-back cycle, together with branches that name busy destinations and idle cycles that carry a destination, show that only accepted register writers book a slot or leave a pending count. A reset in the middle of a floating-point flight confirms that nothing survives reset.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    UC_INT = 2'd0,
    UC_MEM = 2'd1,
    UC_FP  = 2'd2,
    UC_BR  = 2'd3
  } unit_cls_e;

  function automatic logic cls_writes_reg(input logic [1:0] cls);
    return cls != UC_BR;
  endfunction

endpackage

// File: rtl/ilk_pend_table.sv
module ilk_pend_table #(
  parameter int NREG = 32,
  parameter int CW   = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_idx,
  input  logic [CW-1:0] set_val,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  input  logic [AW-1:0] rd_d,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic [CW-1:0] cnt_d
);

  logic [CW-1:0] cnt_q [NREG];

  // One countdown per architectural register: loaded on issue, drained to zero.
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic          hit;
    logic          en;
    logic [CW-1:0] nxt;

    always_comb begin
      hit = set_en && (set_idx == AW'(g));
      en  = hit || (cnt_q[g] != '0);
      if (hit) nxt = set_val;
      else     nxt = cnt_q[g] - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q[g] <= '0;
      else if (en) cnt_q[g] <= nxt;
    end
  end

  assign cnt_a = cnt_q[rd_a];
  assign cnt_b = cnt_q[rd_b];
  assign cnt_d = cnt_q[rd_d];

endmodule

// File: rtl/ilk_wb_ring.sv
module ilk_wb_ring #(
  parameter int DEPTH = 7,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             book_en,
  input  logic [LW-1:0]    book_lat,
  output logic [DEPTH-1:0] slots
);

  // Bit i set in cycle c: a write-back occupies the port in cycle c+i.
  logic [DEPTH-1:0] slot_q;
  logic [DEPTH-1:0] slot_nxt;
  logic             slot_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic upper;
    if (i == DEPTH-1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = slot_q[i+1];
    end
    assign slot_nxt[i] = upper | (book_en && (book_lat == LW'(i+1)));
  end

  assign slot_en = book_en || (|slot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       slot_q <= '0;
    else if (slot_en) slot_q <= slot_nxt;
  end

  assign slots = slot_q;

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard #(
  parameter int DEPTH = 7,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic             valid,
  input  logic             writes,
  input  logic [LW-1:0]    lat,
  input  logic [LW-1:0]    cnt_a,
  input  logic [LW-1:0]    cnt_b,
  input  logic [LW-1:0]    cnt_d,
  input  logic [DEPTH-1:0] slots,
  output logic             raw_o,
  output logic             waw_o,
  output logic             port_o,
  output logic             go_o
);

  always_comb begin
    raw_o  = valid && ((cnt_a != '0) || (cnt_b != '0));
    // Older write lands in cycle c+cnt_d-1, ours in c+lat: ours must be later.
    waw_o  = valid && writes && (cnt_d > lat);
    port_o = valid && writes && slots[lat];
    go_o   = valid && !(raw_o || waw_o || port_o);
  end

endmodule

// File: rtl/ilk_issue_gate.sv
module ilk_issue_gate #(
  parameter int NREG    = 32,
  parameter int LAT_INT = 1,
  parameter int LAT_MEM = 3,
  parameter int LAT_FP  = 6,
  localparam int AW     = $clog2(NREG),
  localparam int DEPTH  = LAT_FP + 1,
  localparam int LW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  logic [1:0]    iss_cls,
  input  logic [AW-1:0] iss_src1,
  input  logic [AW-1:0] iss_src2,
  input  logic [AW-1:0] iss_dst,
  output logic          stall,
  output logic          accept,
  output logic          raw_hit,
  output logic          waw_hit,
  output logic          port_hit
);
  import ilk_pkg::*;

  logic [LW-1:0]    lat;
  logic             writes;
  logic [LW-1:0]    cnt_a, cnt_b, cnt_d;
  logic [DEPTH-1:0] slots;
  logic             go;
  logic             commit_wr;

  always_comb begin
    writes = cls_writes_reg(iss_cls);
    unique case (unit_cls_e'(iss_cls))
      UC_INT:  lat = LW'(LAT_INT);
      UC_MEM:  lat = LW'(LAT_MEM);
      UC_FP:   lat = LW'(LAT_FP);
      default: lat = '0;
    endcase
  end

  ilk_pend_table #(.NREG(NREG), .CW(LW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (commit_wr),
    .set_idx (iss_dst),
    .set_val (lat),
    .rd_a    (iss_src1),
    .rd_b    (iss_src2),
    .rd_d    (iss_dst),
    .cnt_a   (cnt_a),
    .cnt_b   (cnt_b),
    .cnt_d   (cnt_d)
  );

  ilk_wb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .book_en  (commit_wr),
    .book_lat (lat),
    .slots    (slots)
  );

  ilk_hazard #(.DEPTH(DEPTH)) u_haz (
    .valid  (iss_valid),
    .writes (writes),
    .lat    (lat),
    .cnt_a  (cnt_a),
    .cnt_b  (cnt_b),
    .cnt_d  (cnt_d),
    .slots  (slots),
    .raw_o  (raw_hit),
    .waw_o  (waw_hit),
    .port_o (port_hit),
    .go_o   (go)
  );

  assign commit_wr = go && writes;
  assign accept    = go;
  assign stall     = iss_valid && !go;

endmodule

// File: rtl/ilk_issue_gate_chk.sv
module ilk_issue_gate_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic [1:0]    iss_cls,
  input logic [AW-1:0] iss_src1,
  input logic [AW-1:0] iss_src2,
  input logic [AW-1:0] iss_dst,
  input logic          stall,
  input logic          accept,
  input logic          raw_hit,
  input logic          waw_hit,
  input logic          port_hit
);

  // Edges seen since reset, saturating, so $past never reaches before reset.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_DECISION_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && accept)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> (!stall && !accept && !raw_hit && !waw_hit && !port_hit)); // R2

  AST_BRANCH_NO_WB_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cls == 2'd3) |-> (!waw_hit && !port_hit)); // R7

  AST_RAW_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1 && $past(accept) && $past(iss_cls) != 2'd3 && iss_valid &&
     (iss_src1 == $past(iss_dst) || iss_src2 == $past(iss_dst)))
    |-> (raw_hit && !accept)); // R3

  AST_WAW_FP_THEN_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd1 && $past(accept) && $past(iss_cls) == 2'd2 && iss_valid &&
     iss_cls == 2'd0 && iss_dst == $past(iss_dst)) |-> waw_hit); // R5

  AST_PORT_MEM_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(accept, 2) && $past(iss_cls, 2) == 2'd1 && iss_valid &&
     iss_cls == 2'd0) |-> (port_hit && !accept)); // R6

  AST_STALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (raw_hit || waw_hit || port_hit)); // R9

endmodule

bind ilk_issue_gate ilk_issue_gate_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_cls   (iss_cls),
  .iss_src1  (iss_src1),
  .iss_src2  (iss_src2),
  .iss_dst   (iss_dst),
  .stall     (stall),
  .accept    (accept),
  .raw_hit   (raw_hit),
  .waw_hit   (waw_hit),
  .port_hit  (port_hit)
);

// File: tb/ilk_issue_gate_tb.sv
module ilk_issue_gate_tb_top;

  localparam int CYC = 20; // 50 MHz
  localparam int NV  = 22;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       iss_valid;
  logic [1:0] iss_cls;
  logic [4:0] iss_src1, iss_src2, iss_dst;
  logic       stall, accept, raw_hit, waw_hit, port_hit;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CYC/2) clk = ~clk;

  ilk_issue_gate dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_cls   (iss_cls),
    .iss_src1  (iss_src1),
    .iss_src2  (iss_src2),
    .iss_dst   (iss_dst),
    .stall     (stall),
    .accept    (accept),
    .raw_hit   (raw_hit),
    .waw_hit   (waw_hit),
    .port_hit  (port_hit)
  );

  // Row: valid, cls, src1, src2, dst, expected {accept, raw, waw, port}, requirement.
  // One row per cycle, driven back to back from the first cycle after reset.
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 2'd0, 5'd1,  5'd2,  5'd3,  4'b1000, 4'd1}, // c0  R1 first issue accepted
    {1'b1, 2'd0, 5'd3,  5'd4,  5'd5,  4'b0100, 4'd3}, // c1  R3 int producer, 1 stall
    {1'b1, 2'd0, 5'd3,  5'd4,  5'd5,  4'b1000, 4'd3}, // c2  R3 issues at t+2
    {1'b1, 2'd2, 5'd6,  5'd7,  5'd8,  4'b1000, 4'd3}, // c3  fp to r8, writes c9
    {1'b1, 2'd0, 5'd9,  5'd8,  5'd10, 4'b0100, 4'd4}, // c4  R4 second source pending
    {1'b1, 2'd0, 5'd1,  5'd2,  5'd8,  4'b0010, 4'd5}, // c5  R5 int would write r8 first
    {1'b1, 2'd1, 5'd1,  5'd2,  5'd8,  4'b0011, 4'd9}, // c6  R9 waw and port together
    {1'b1, 2'd1, 5'd1,  5'd2,  5'd8,  4'b1000, 4'd5}, // c7  R5 mem now lands after fp
    {1'b1, 2'd0, 5'd1,  5'd2,  5'd11, 4'b0001, 4'd6}, // c8  R6 clashes with fp at c9
    {1'b1, 2'd0, 5'd1,  5'd2,  5'd11, 4'b0001, 4'd6}, // c9  R6 clashes with mem at c10
    {1'b1, 2'd0, 5'd1,  5'd2,  5'd11, 4'b1000, 4'd6}, // c10 R6 free slot
    {1'b1, 2'd3, 5'd1,  5'd2,  5'd11, 4'b1000, 4'd7}, // c11 R7 branch on busy dst
    {1'b1, 2'd0, 5'd11, 5'd12, 5'd13, 4'b1000, 4'd7}, // c12 R7 branch left r11 clean
    {1'b0, 2'd2, 5'd1,  5'd2,  5'd14, 4'b0000, 4'd8}, // c13 R8 idle cycle
    {1'b1, 2'd0, 5'd14, 5'd0,  5'd15, 4'b1000, 4'd8}, // c14 R8 idle left r14 clean
    {1'b1, 2'd1, 5'd15, 5'd0,  5'd16, 4'b0100, 4'd3}, // c15 R3
    {1'b1, 2'd1, 5'd15, 5'd0,  5'd16, 4'b1000, 4'd3}, // c16 mem to r16, writes c19
    {1'b1, 2'd0, 5'd16, 5'd0,  5'd17, 4'b0100, 4'd3}, // c17 R3
    {1'b1, 2'd0, 5'd16, 5'd0,  5'd17, 4'b0101, 4'd9}, // c18 R9 raw and port together
    {1'b1, 2'd0, 5'd16, 5'd0,  5'd17, 4'b0100, 4'd3}, // c19 R3
    {1'b1, 2'd0, 5'd16, 5'd0,  5'd17, 4'b1000, 4'd3}, // c20 R3 mem reader at t+4
    {1'b1, 2'd3, 5'd16, 5'd16, 5'd0,  4'b1000, 4'd7}  // c21 R7 branch issues
  };

  task automatic drive(input logic v, input logic [1:0] c,
                       input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    iss_valid = v;
    iss_cls   = c;
    iss_src1  = a;
    iss_src2  = b;
    iss_dst   = d;
  endtask

  // Compares {accept, stall, raw, waw, port}; R2 rides on every call.
  task automatic check(input int req, input logic v, input logic [3:0] exp4);
    logic [4:0] act;
    logic [4:0] exp;
    act = {accept, stall, raw_hit, waw_hit, port_hit};
    exp = {exp4[3], v & ~exp4[3], exp4[2:0]};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d t=%0t {acc,stall,raw,waw,port} actual=%b expected=%b",
               req, $time, act, exp);
    end
  endtask

  initial begin
    #(CYC * 5000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    #1;
    // R1: during reset, with clear state, a candidate is accepted.
    drive(1'b1, 2'd2, 5'd4, 5'd5, 5'd6);
    #1;
    check(1, 1'b1, 4'b1000);
    // R2: nothing offered, nothing decided.
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    #1;
    check(2, 1'b0, 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25], VEC[i][24:23], VEC[i][22:18], VEC[i][17:13], VEC[i][12:8]);
      #(CYC/4);
      check(int'(VEC[i][3:0]), VEC[i][25], VEC[i][7:4]);
      @(negedge clk);
    end

    // R1: reset during a floating-point flight clears its pending write and slot.
    drive(1'b1, 2'd2, 5'd1, 5'd2, 5'd20);
    #(CYC/4);
    check(1, 1'b1, 4'b1000);
    @(negedge clk);
    drive(1'b1, 2'd0, 5'd20, 5'd1, 5'd21);
    #(CYC/4);
    check(3, 1'b1, 4'b0100); // R3 still pending before reset
    @(negedge clk);
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 2'd0, 5'd20, 5'd1, 5'd21);
    #(CYC/4);
    check(1, 1'b1, 4'b1000);
    @(negedge clk);
    // R5: fp then int to the same register right behind it.
    drive(1'b1, 2'd2, 5'd1, 5'd2, 5'd22);
    #(CYC/4);
    check(5, 1'b1, 4'b1000);
    @(negedge clk);
    drive(1'b1, 2'd0, 5'd1, 5'd2, 5'd22);
    #(CYC/4);
    check(5, 1'b1, 4'b0010);
    @(negedge clk);
    drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule